// File: doc/BRIEF.md
# Link Power State Controller

This block is the device-side state machine that follows the operating state of a host-device link. It leaves its reset state by itself once internal initialisation is finished. After that the host steers it through a target-state write port. The device can also move on its own initiative: it suspends when the physical link goes idle, drops into a deeper low-power state when the idle period lasts, and resumes when a wake event or a doorbell write arrives.

Every state drives two gates. One allows register (MMIO) access and the other enables channel processing. Every state change raises a one-cycle event strobe that carries the new state code. An event-ring producer uses this strobe to report the change to the host.

State codes: RESET=0, READY=1, ACTIVE=2, DSUSP (device-suspended)=3, LOWPWR=4, HSTOP (host-stopped)=5. The parameter `LP_CYC` (default 8) sets how many idle cycles in DSUSP lead to LOWPWR.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `state_o` is RESET (0), `mmio_ok` and `proc_en` are 0 and `evt_vld` is 0. Reset acts asynchronously.
- R2: In RESET, `init_done` moves the state to READY (1) at the next clock edge. RESET is left by no other means, and `init_done` has no effect in any other state.
- R3: In READY, a host write (`tgt_wr`=1) of code 2 moves the state to ACTIVE (2).
- R4: In ACTIVE, `link_idle`=1 moves the state to DSUSP (3) at the next edge.
- R5: In DSUSP, `link_idle` held high for `LP_CYC` consecutive cycles moves the state to LOWPWR (4) at the edge that ends the last of them. A cycle with `link_idle` low restarts the count.
- R6: In DSUSP or LOWPWR, `wake`=1 or `db_ring`=1 moves the state to ACTIVE. These inputs have no effect in any other state.
- R7: A host write of code 5 moves ACTIVE, DSUSP or LOWPWR to HSTOP (5). A host write of code 2 moves HSTOP to ACTIVE. In HSTOP, idle and wake inputs have no effect.
- R8: A host write of code 0 moves any state other than RESET back to RESET.
- R9: A host write that is not listed in R3, R7 or R8 is ignored. This includes every write made while in RESET and every write of codes 1, 3, 4, 6 and 7. The state and `evt_vld` stay unchanged.
- R10: `mmio_ok` is 1 in every state except RESET. `proc_en` is 1 only in ACTIVE.
- R11: When the state changes, `evt_vld` is 1 for the cycle in which `state_o` first shows the new state, and `evt_code` equals that new state. `evt_vld` is 0 whenever the state did not change.
- R12: A legal host write takes priority over wake, doorbell, idle and the low-power timer. A wake or doorbell takes priority over the low-power timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| init_done | input | 1 | Internal initialisation complete |
| tgt_wr | input | 1 | Host write strobe for the target state |
| tgt_state | input | 3 | Target state code written by the host |
| link_idle | input | 1 | Physical-link inactivity detected |
| wake | input | 1 | Wake event |
| db_ring | input | 1 | Doorbell write seen |
| state_o | output | 3 | Current state code |
| mmio_ok | output | 1 | Register access allowed |
| proc_en | output | 1 | Channel processing enabled |
| evt_vld | output | 1 | One-cycle state-change strobe |
| evt_code | output | 3 | New state code carried by the strobe |

## Verification
The properties assume that the host write, idle, wake and doorbell inputs are synchronous to `clk` and stable around each rising edge. The idle and wake properties only hold on cycles without a host write, so they are guarded by `!tgt_wr`. The stimulus changes every input at the falling edge, and it combines host writes with wake or idle inputs only in rows that test the priority order. Reset is the one input pulsed off-edge, because it is meant to be asynchronous.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_READY  = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_DSUSP  = 3'd3,
        ST_LOWPWR = 3'd4,
        ST_HSTOP  = 3'd5
    } lstate_e;

    localparam int unsigned STW = 3;

    typedef struct packed {
        lstate_e st;
        logic    evt;
        lstate_e evt_code;
    } lpc_regs_t;

    localparam lpc_regs_t LPC_RST = '{st: ST_RESET, evt: 1'b0, evt_code: ST_RESET};

endpackage

// File: rtl/lpc_host_decode.sv
// Filters host target-state writes against the current state (R3, R7, R8, R9).
module lpc_host_decode
    import lpc_pkg::*;
(
    input  lstate_e            cur,
    input  logic               wr_en,
    input  logic [STW-1:0]     wr_code,
    output logic               req_vld,
    output lstate_e            req_st
);
    always_comb begin
        req_vld = 1'b0;
        req_st  = cur;
        if (wr_en) begin
            case (wr_code)
                3'd0: begin                                   // R8
                    if (cur != ST_RESET) begin
                        req_vld = 1'b1;
                        req_st  = ST_RESET;
                    end
                end
                3'd2: begin                                   // R3, R7
                    if (cur == ST_READY || cur == ST_HSTOP) begin
                        req_vld = 1'b1;
                        req_st  = ST_ACTIVE;
                    end
                end
                3'd5: begin                                   // R7
                    if (cur == ST_ACTIVE || cur == ST_DSUSP || cur == ST_LOWPWR) begin
                        req_vld = 1'b1;
                        req_st  = ST_HSTOP;
                    end
                end
                default: ;                                    // R9
            endcase
        end
    end
endmodule

// File: rtl/lpc_dwell_timer.sv
// Counts consecutive idle cycles spent in the suspended state (R5).
module lpc_dwell_timer #(
    parameter int unsigned LP_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = $clog2(LP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(LP_CYC - 1);
    localparam logic [CW-1:0] TOP  = CW'(LP_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q != TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && (cnt_q == LAST);
endmodule

// File: rtl/lpc_next.sv
// Next-state selection with the priority of R12.
module lpc_next
    import lpc_pkg::*;
(
    input  lstate_e cur,
    input  logic    init_done,
    input  logic    req_vld,
    input  lstate_e req_st,
    input  logic    link_idle,
    input  logic    wake_any,
    input  logic    lp_expire,
    output lstate_e nxt
);
    always_comb begin
        nxt = cur;
        if (req_vld) begin
            nxt = req_st;
        end else begin
            case (cur)
                ST_RESET:  if (init_done) nxt = ST_READY;      // R2
                ST_ACTIVE: if (link_idle) nxt = ST_DSUSP;      // R4
                ST_DSUSP: begin
                    if (wake_any)       nxt = ST_ACTIVE;       // R6
                    else if (lp_expire) nxt = ST_LOWPWR;       // R5
                end
                ST_LOWPWR: if (wake_any) nxt = ST_ACTIVE;      // R6
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
    import lpc_pkg::*;
#(
    parameter int unsigned LP_CYC = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           init_done,
    input  logic           tgt_wr,
    input  logic [STW-1:0] tgt_state,
    input  logic           link_idle,
    input  logic           wake,
    input  logic           db_ring,
    output logic [STW-1:0] state_o,
    output logic           mmio_ok,
    output logic           proc_en,
    output logic           evt_vld,
    output logic [STW-1:0] evt_code
);
    lpc_regs_t r_d, r_q;
    logic      req_vld;
    lstate_e   req_st;
    lstate_e   nxt;
    logic      lp_expire;
    logic      tmr_run;

    lpc_host_decode u_dec (
        .cur     (r_q.st),
        .wr_en   (tgt_wr),
        .wr_code (tgt_state),
        .req_vld (req_vld),
        .req_st  (req_st)
    );

    assign tmr_run = (r_q.st == ST_DSUSP) && link_idle;

    lpc_dwell_timer #(.LP_CYC(LP_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .expire (lp_expire)
    );

    lpc_next u_nxt (
        .cur       (r_q.st),
        .init_done (init_done),
        .req_vld   (req_vld),
        .req_st    (req_st),
        .link_idle (link_idle),
        .wake_any  (wake | db_ring),
        .lp_expire (lp_expire),
        .nxt       (nxt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.st  = nxt;
        r_d.evt = (nxt != r_q.st);
        if (nxt != r_q.st)
            r_d.evt_code = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= LPC_RST;
        else        r_q <= r_d;
    end

    assign state_o  = r_q.st;
    assign mmio_ok  = (r_q.st != ST_RESET);
    assign proc_en  = (r_q.st == ST_ACTIVE);
    assign evt_vld  = r_q.evt;
    assign evt_code = r_q.evt_code;
endmodule

// File: rtl/lpc_checks.sv
module lpc_checks
    import lpc_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           tgt_wr,
    input logic           link_idle,
    input logic           wake,
    input logic           db_ring,
    input logic [STW-1:0] state_o,
    input logic           mmio_ok,
    input logic           proc_en,
    input logic           evt_vld,
    input logic [STW-1:0] evt_code
);
    p_reset_gate_r1: assert property (@(posedge clk)
        (state_o == ST_RESET) |-> (!mmio_ok && !proc_en));

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proc_en |-> (mmio_ok && state_o == ST_ACTIVE));

    p_leave_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == ST_RESET && state_o != ST_RESET) |-> (state_o == ST_READY));

    p_idle_susp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ACTIVE && link_idle && !tgt_wr) |=> (state_o == ST_DSUSP));

    p_lp_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_LOWPWR && $past(state_o) != ST_LOWPWR) |-> ($past(state_o) == ST_DSUSP));

    p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == ST_DSUSP || state_o == ST_LOWPWR) && (wake || db_ring) && !tgt_wr)
        |=> (state_o == ST_ACTIVE));

    p_evt_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != $past(state_o)) |-> (evt_vld && evt_code == state_o));

    p_evt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == $past(state_o)) |-> !evt_vld);
endmodule

bind link_pwr_ctrl lpc_checks u_lpc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_wr    (tgt_wr),
    .link_idle (link_idle),
    .wake      (wake),
    .db_ring   (db_ring),
    .state_o   (state_o),
    .mmio_ok   (mmio_ok),
    .proc_en   (proc_en),
    .evt_vld   (evt_vld),
    .evt_code  (evt_code)
);

// File: tb/link_pwr_ctrl_test.sv
module link_pwr_ctrl_test;
    localparam int LPC = 4;
    localparam int NROW = 33;
    // row: init | wr | code[3] | idle | wake | db | exp_state[3] | exp_evt | req[4]
    localparam logic [15:0] VEC [NROW] = '{
        16'b0_0_000_000_000_0_0001, // 0  R1 idle in reset
        16'b0_1_010_000_000_0_1001, // 1  R9 write in reset ignored
        16'b1_0_000_000_001_1_0010, // 2  R2 init done
        16'b0_1_101_000_001_0_1001, // 3  R9 stop from READY illegal
        16'b0_1_111_000_001_0_1001, // 4  R9 code 7
        16'b0_1_010_000_010_1_0011, // 5  R3 enter ACTIVE
        16'b0_0_000_010_010_0_0110, // 6  R6 wake in ACTIVE no effect
        16'b0_1_010_000_010_0_1001, // 7  R9 ACTIVE->ACTIVE illegal
        16'b0_0_000_100_011_1_0100, // 8  R4 idle suspends
        16'b0_0_000_010_010_1_0110, // 9  R6 wake resumes
        16'b0_1_101_100_101_1_1100, // 10 R12 stop beats idle
        16'b0_0_000_100_101_0_0111, // 11 R7 idle in HSTOP
        16'b0_0_000_010_101_0_0111, // 12 R7 wake in HSTOP
        16'b0_1_010_000_010_1_0111, // 13 R7 HSTOP->ACTIVE
        16'b0_0_000_100_011_1_0100, // 14 R4
        16'b0_0_000_100_011_0_0101, // 15 R5 count 1
        16'b0_0_000_100_011_0_0101, // 16 R5 count 2
        16'b0_0_000_100_011_0_0101, // 17 R5 count 3
        16'b0_0_000_100_100_1_0101, // 18 R5 count 4 -> LOWPWR
        16'b0_0_000_100_100_0_0101, // 19 R5 stays
        16'b0_0_000_001_010_1_0110, // 20 R6 doorbell resumes
        16'b0_0_000_100_011_1_0100, // 21 R4
        16'b0_0_000_100_011_0_0101, // 22 R5
        16'b0_0_000_000_011_0_0101, // 23 R5 idle gap restarts
        16'b0_0_000_100_011_0_0101, // 24 R5
        16'b0_0_000_100_011_0_0101, // 25 R5
        16'b0_0_000_100_011_0_0101, // 26 R5
        16'b0_0_000_100_100_1_0101, // 27 R5 full count after restart
        16'b0_1_101_010_101_1_1100, // 28 R12 stop beats wake
        16'b0_1_000_000_000_1_1000, // 29 R8 back to reset
        16'b0_0_000_000_000_0_0010, // 30 R2 no self exit
        16'b1_0_000_000_001_1_0010, // 31 R2
        16'b0_1_000_000_000_1_1000  // 32 R8 from READY
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_done = 1'b0, tgt_wr = 1'b0, link_idle = 1'b0, wake = 1'b0, db_ring = 1'b0;
    logic [2:0] tgt_state = 3'd0;
    logic [2:0] state_o, evt_code;
    logic       mmio_ok, proc_en, evt_vld;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    link_pwr_ctrl #(.LP_CYC(LPC)) uut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .tgt_wr(tgt_wr),
        .tgt_state(tgt_state), .link_idle(link_idle), .wake(wake), .db_ring(db_ring),
        .state_o(state_o), .mmio_ok(mmio_ok), .proc_en(proc_en),
        .evt_vld(evt_vld), .evt_code(evt_code)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int st, input bit ev);
        chk(tag, "state", state_o, st);
        chk(tag, "evt_vld", evt_vld, ev);
        if (ev) chk("R11", "evt_code", evt_code, st);
        chk("R10", "mmio_ok", mmio_ok, st != 0);
        chk("R10", "proc_en", proc_en, st == 2);
    endtask

    task automatic drive(input bit i, input bit w, input int c, input bit l, input bit k, input bit d);
        init_done = i; tgt_wr = w; tgt_state = 3'(c); link_idle = l; wake = k; db_ring = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1", 0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 0, 1'b0);

        for (int r = 0; r < NROW; r++) begin
            logic [15:0] v;
            v = VEC[r];
            drive(v[15], v[14], int'(v[13:11]), v[10], v[9], v[8]);
            @(negedge clk);
            chk_all($sformatf("R%0d row%0d", int'(v[3:0]), r), int'(v[7:5]), v[4]);
        end

        drive(1, 0, 0, 0, 0, 0); @(negedge clk); chk_all("R2", 1, 1'b1);
        @(negedge clk);                          chk_all("R2", 1, 1'b0); // init_done held in READY
        drive(0, 1, 2, 0, 0, 0); @(negedge clk); chk_all("R3", 2, 1'b1);
        drive(0, 1, 4, 0, 0, 0); @(negedge clk); chk_all("R9", 2, 1'b0);
        drive(0, 0, 0, 1, 0, 0); @(negedge clk); chk_all("R4", 3, 1'b1);
        drive(0, 1, 2, 0, 0, 0); @(negedge clk); chk_all("R9", 3, 1'b0);
        drive(0, 1, 5, 0, 1, 1); @(negedge clk); chk_all("R12", 5, 1'b1);
        drive(0, 1, 2, 0, 0, 0); @(negedge clk); chk_all("R7", 2, 1'b1);
        drive(0, 0, 0, 0, 0, 0);
        #5 rst_n = 1'b0;
        #2 chk_all("R1", 0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); chk_all("R1", 0, 1'b0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule